// File: doc/BRIEF.md
# Channel isolation and partial boundary scan

This block sits between the pins of an eight-channel routing component and its routing core. Four channels are inputs; four are outputs, grouped as two logical directions with two equivalent ports each. Software reaches the block over a small serial scan port. Through that port it writes an eight-bit channel enable register, one bit per channel, and an eight-bit segment mask. Clearing an enable bit cuts a channel off from the core. A disabled input channel never hands a valid to the core and never returns ready to its sender. A disabled output port is never chosen; its direction's traffic goes to the other port of the pair.

The boundary cells are split into one segment per channel. A partial scan selection puts only a chosen subset of the segments between the scan input and output; every other segment is bypassed by a mux and adds nothing to the shift length. A segment takes part only when its mask bit is set and its enable bit is clear. Only those channels enter test mode, so the rest of the component keeps routing while the scan runs.

Channel traffic uses valid/ready. An enabled input channel passes valid, data and ready straight through, with no added cycle. A direction's ready is the ready of the port chosen for it, so back-pressure from that port stalls the direction. Ready from the other port is ignored. The scan port is plain control: capture, shift and update strobes and a two-bit register select.

Top module: `chan_isolate`

## Requirements
- R1: After reset every enable bit is 1 and every mask bit is 0, and both read back as such through the scan port.
- R2: A register is written by shifting 8 bits, bit 0 first, with scan_shift high and then pulsing scan_update. It is read by pulsing scan_capture and then taking scan_tdo before each of 8 shifts, bit 0 first. scan_sel selects the register: 0 bypass, 1 enable, 2 mask, 3 partial scan.
- R3: While an input channel's enable bit is 0, its core_valid and in_ready are 0 whatever the other side does.
- R4: While an input channel's enable bit is 1, core_valid equals in_valid, in_ready equals core_ready and core_data equals in_data, in the same cycle.
- R5: Output channel k (0-3) is enable bit 4+k and belongs to direction k/2. A direction drives its even port if that port is enabled, otherwise its odd port if enabled, otherwise neither. The chosen port carries dir_valid and dir_data.
- R6: dir_ready equals out_ready of the chosen port, and is 0 when neither port is enabled. The other port's ready has no effect.
- R7: With scan_sel at 3, the scan path is 3 cells (valid plus 2 data bits) for each channel whose mask bit is 1 and enable bit is 0. When no channel qualifies, the path is a single bypass stage.
- R8: A channel with its mask bit set but its enable bit set adds no cells to the path, and its pins stay functional.
- R9: On capture, each selected segment loads cell 0 with its channel's valid and cells 1-2 with data bits 0-1. Input channels take their pins; output channels take the value the router would drive. Shifting moves cells toward scan_tdo, the lowest-numbered selected segment nearest the output and cell 0 first.
- R10: Under scan_sel 3, an output channel in test mode drives out_valid and out_data from the values last updated into its segment. Under any other scan_sel, the port returns to normal function.
- R11: During a partial scan, channels not in test mode keep their normal pass-through and steering.
- R12: With scan_sel at 0, scan_tdo shows scan_tdi delayed by exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for scan and configuration state |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_sel | input | 2 | Register select between scan_tdi and scan_tdo |
| scan_capture | input | 1 | Load the selected register's shadow from live state or pins |
| scan_shift | input | 1 | Shift the selected path by one position |
| scan_update | input | 1 | Copy the shadow to the live register or boundary outputs |
| scan_tdi | input | 1 | Serial scan input |
| scan_tdo | output | 1 | Serial scan output |
| in_valid | input | 4 | Input channel valid from senders |
| in_ready | output | 4 | Input channel ready back to senders |
| in_data | input | 4x2 | Input channel data |
| core_valid | output | 4 | Valid toward the routing core |
| core_ready | input | 4 | Ready from the routing core |
| core_data | output | 4x2 | Data toward the routing core |
| dir_valid | input | 2 | Core request per logical output direction |
| dir_ready | output | 2 | Acceptance per direction from the chosen port |
| dir_data | input | 2x2 | Data per direction |
| out_valid | output | 4 | Output port valid |
| out_ready | input | 4 | Output port ready from receivers |
| out_data | output | 4x2 | Output port data |

## Verification
The hardest state to reach from the ports is a partial scan where some channels are in test mode, a masked channel is kept out by its enable bit, and its neighbours keep routing. All of that has to be set up through serial writes before anything can be observed. The bench first sweeps all 256 enable patterns with every mask bit set. For each pattern it measures the scan path length by pushing a single marker bit through, and it checks gating and steering under each of the 16 out_ready patterns. A directed case then captures known pin values through two test segments past a masked but enabled channel. It checks the serial bit order, updates an output port into test drive, and watches the port fall back when the selection changes.

// File: rtl/chan_iso_pkg.sv
package chan_iso_pkg;
  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_PSCAN  = 2'd3
  } scan_sel_e;
endpackage

// File: rtl/cfg_shift_reg.sv
// Scan-accessible configuration register: shadow shift stage plus live copy.
module cfg_shift_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         si,
  output logic         so,
  output logic [W-1:0] q
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      q      <= RST_VAL;
    end else if (capture) begin
      shadow <= q;
    end else if (shift) begin
      shadow <= {si, shadow[W-1:1]};
    end else if (update) begin
      q <= shadow;
    end
  end

  assign so = shadow[0];

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(q));
endmodule

// File: rtl/bscan_segment.sv
// One channel's slice of the boundary path, skipped by a mux when not selected.
module bscan_segment #(
  parameter int unsigned CELLS = 3,
  parameter bit          DRIVES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic [CELLS-1:0] cap_i,
  input  logic             si,
  output logic             so,
  output logic [CELLS-1:0] upd_o
);
  logic [CELLS-1:0] cells;
  logic [CELLS-1:0] shifted;

  generate
    if (CELLS == 1) begin : g_one
      assign shifted = si;
    end else begin : g_many
      assign shifted = {si, cells[CELLS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (sel_i && capture) begin
      cells <= cap_i;
    end else if (sel_i && shift) begin
      cells <= shifted;
    end
  end

  generate
    if (DRIVES) begin : g_upd
      logic [CELLS-1:0] upd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           upd_q <= '0;
        else if (sel_i && update && !capture && !shift) upd_q <= cells;
      end
      assign upd_o = upd_q;
    end else begin : g_noupd
      assign upd_o = '0;
    end
  endgenerate

  assign so = sel_i ? cells[0] : si;

  // R8
  seg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(cells));
  // R7
  seg_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> (so == si));
endmodule

// File: rtl/port_steer.sv
// Picks one of a direction's two equivalent ports, avoiding disabled ones.
module port_steer #(
  parameter int unsigned DW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         en,
  input  logic [1:0]         test,
  input  logic               dir_valid,
  input  logic [DW-1:0]      dir_data,
  output logic               dir_ready,
  input  logic [1:0]         upd_valid,
  input  logic [1:0][DW-1:0] upd_data,
  output logic [1:0]         func_valid,
  output logic [1:0]         out_valid,
  output logic [1:0][DW-1:0] out_data,
  input  logic [1:0]         out_ready
);
  logic pick0, pick1;

  assign pick0 = en[0];
  assign pick1 = !en[0] && en[1];
  assign func_valid = {pick1 && dir_valid, pick0 && dir_valid};
  assign dir_ready  = (pick0 && out_ready[0]) || (pick1 && out_ready[1]);

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      out_valid[k] = test[k] ? upd_valid[k] : func_valid[k];
      out_data[k]  = test[k] ? upd_data[k]  : dir_data;
    end
  end

  // R5
  steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test == 2'b00) |-> !(out_valid[0] && out_valid[1]));
  // R5
  steer_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[1] && !test[1]) |-> !out_valid[1]);
  // R6
  steer_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ready |-> ((en[0] && out_ready[0]) || (en[1] && out_ready[1])));
endmodule

// File: rtl/chan_isolate.sv
module chan_isolate
  import chan_iso_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_DIR = 2,
  parameter int unsigned DW    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    scan_sel,
  input  logic                          scan_capture,
  input  logic                          scan_shift,
  input  logic                          scan_update,
  input  logic                          scan_tdi,
  output logic                          scan_tdo,
  input  logic [N_IN-1:0]               in_valid,
  output logic [N_IN-1:0]               in_ready,
  input  logic [N_IN-1:0][DW-1:0]       in_data,
  output logic [N_IN-1:0]               core_valid,
  input  logic [N_IN-1:0]               core_ready,
  output logic [N_IN-1:0][DW-1:0]       core_data,
  input  logic [N_DIR-1:0]              dir_valid,
  output logic [N_DIR-1:0]              dir_ready,
  input  logic [N_DIR-1:0][DW-1:0]      dir_data,
  output logic [2*N_DIR-1:0]            out_valid,
  input  logic [2*N_DIR-1:0]            out_ready,
  output logic [2*N_DIR-1:0][DW-1:0]    out_data
);
  localparam int unsigned N_OUT = 2 * N_DIR;
  localparam int unsigned N_CH  = N_IN + N_OUT;
  localparam int unsigned CELLS = DW + 1;

  scan_sel_e sel;
  assign sel = scan_sel_e'(scan_sel);

  logic [N_CH-1:0] en_q, mask_q, seg_sel;
  logic            en_so, mask_so, byp_q, pscan;
  logic [N_CH:0]   link;

  logic [N_OUT-1:0]          func_valid;
  logic [N_OUT-1:0]          upd_valid;
  logic [N_OUT-1:0][DW-1:0]  upd_data;
  logic [N_CH-1:0][CELLS-1:0] cap_all;

  cfg_shift_reg #(.W(N_CH), .RST_VAL({N_CH{1'b1}})) u_en (
    .clk(clk), .rst_n(rst_n),
    .capture(scan_capture && sel == SEL_ENABLE),
    .shift(scan_shift && sel == SEL_ENABLE),
    .update(scan_update && sel == SEL_ENABLE),
    .si(scan_tdi), .so(en_so), .q(en_q)
  );

  cfg_shift_reg #(.W(N_CH), .RST_VAL('0)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .capture(scan_capture && sel == SEL_MASK),
    .shift(scan_shift && sel == SEL_MASK),
    .update(scan_update && sel == SEL_MASK),
    .si(scan_tdi), .so(mask_so), .q(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          byp_q <= 1'b0;
    else if (scan_shift) byp_q <= scan_tdi;
  end

  assign pscan   = (sel == SEL_PSCAN);
  assign seg_sel = pscan ? (mask_q & ~en_q) : '0;

  // Input channel gating toward and from the core.
  assign core_valid = in_valid & en_q[N_IN-1:0];
  assign in_ready   = core_ready & en_q[N_IN-1:0];
  assign core_data  = in_data;

  // Output steering, one pair of ports per direction.
  genvar d;
  generate
    for (d = 0; d < N_DIR; d++) begin : g_dir
      port_steer #(.DW(DW)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .en(en_q[N_IN+2*d +: 2]),
        .test(seg_sel[N_IN+2*d +: 2]),
        .dir_valid(dir_valid[d]),
        .dir_data(dir_data[d]),
        .dir_ready(dir_ready[d]),
        .upd_valid(upd_valid[2*d +: 2]),
        .upd_data(upd_data[2*d +: 2]),
        .func_valid(func_valid[2*d +: 2]),
        .out_valid(out_valid[2*d +: 2]),
        .out_data(out_data[2*d +: 2]),
        .out_ready(out_ready[2*d +: 2])
      );
    end
  endgenerate

  // Boundary segments, chained from scan_tdi (highest channel) to link[0].
  assign link[N_CH] = scan_tdi;

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_seg
      if (c < N_IN) begin : g_in
        logic [CELLS-1:0] upd_unused;
        assign cap_all[c] = {in_data[c], in_valid[c]};
        bscan_segment #(.CELLS(CELLS), .DRIVES(1'b0)) u_seg (
          .clk(clk), .rst_n(rst_n), .sel_i(seg_sel[c]),
          .capture(scan_capture), .shift(scan_shift), .update(scan_update),
          .cap_i(cap_all[c]), .si(link[c+1]), .so(link[c]),
          .upd_o(upd_unused)
        );
      end else begin : g_out
        logic [CELLS-1:0] upd_cells;
        assign cap_all[c] = {dir_data[(c-N_IN)/2], func_valid[c-N_IN]};
        assign upd_valid[c-N_IN] = upd_cells[0];
        assign upd_data[c-N_IN]  = upd_cells[CELLS-1:1];
        bscan_segment #(.CELLS(CELLS), .DRIVES(1'b1)) u_seg (
          .clk(clk), .rst_n(rst_n), .sel_i(seg_sel[c]),
          .capture(scan_capture), .shift(scan_shift), .update(scan_update),
          .cap_i(cap_all[c]), .si(link[c+1]), .so(link[c]),
          .upd_o(upd_cells)
        );
      end
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_ENABLE: scan_tdo = en_so;
      SEL_MASK:   scan_tdo = mask_so;
      SEL_PSCAN:  scan_tdo = (|seg_sel) ? link[0] : byp_q;
      default:    scan_tdo = byp_q;
    endcase
  end

  generate
    for (c = 0; c < N_IN; c++) begin : g_in_chk
      // R3
      in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[c] |-> (!in_ready[c] && !core_valid[c]));
    end
    for (c = 0; c < N_OUT; c++) begin : g_out_chk
      // R10
      test_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pscan && !en_q[N_IN+c]) |-> !out_valid[c]);
    end
  endgenerate

  // R12
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_BYPASS && $past(scan_shift) && $past(sel) == SEL_BYPASS)
      |-> (scan_tdo == $past(scan_tdi)));
endmodule

// File: tb/sim_chan_isolate.sv
`timescale 1ns/1ps
module sim_chan_isolate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] scan_sel = 2'd0;
  logic scan_capture = 1'b0, scan_shift = 1'b0, scan_update = 1'b0, scan_tdi = 1'b0;
  logic scan_tdo;
  logic [3:0] in_valid = '0, in_ready, core_valid, core_ready = '0;
  logic [3:0][1:0] in_data = '0, core_data;
  logic [1:0] dir_valid = '0, dir_ready;
  logic [1:0][1:0] dir_data = '0;
  logic [3:0] out_valid, out_ready = '0;
  logic [3:0][1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  chan_isolate u0 (
    .clk(clk), .rst_n(rst_n), .scan_sel(scan_sel),
    .scan_capture(scan_capture), .scan_shift(scan_shift), .scan_update(scan_update),
    .scan_tdi(scan_tdi), .scan_tdo(scan_tdo),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .core_valid(core_valid), .core_ready(core_ready), .core_data(core_data),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_data(dir_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] v);
    scan_sel = s;
    scan_shift = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scan_tdi = v[i];
      tick();
    end
    scan_shift = 1'b0;
    scan_update = 1'b1;
    tick();
    scan_update = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
    scan_sel = s;
    scan_capture = 1'b1;
    tick();
    scan_capture = 1'b0;
    scan_shift = 1'b1;
    for (int i = 0; i < 8; i++) begin
      v[i] = scan_tdo;
      tick();
    end
    scan_shift = 1'b0;
  endtask

  task automatic chain_len(output int n);
    scan_sel = 2'd3;
    scan_shift = 1'b1;
    scan_tdi = 1'b0;
    repeat (40) tick();
    scan_tdi = 1'b1;
    tick();
    scan_tdi = 1'b0;
    n = 1;
    while (scan_tdo !== 1'b1 && n < 60) begin
      tick();
      n++;
    end
    scan_shift = 1'b0;
  endtask

  task automatic check_inputs(input logic [7:0] en, input string req);
    in_valid = 4'hF;
    core_ready = 4'hF;
    in_data = {2'd3, 2'd2, 2'd1, 2'd0};
    #1;
    check(core_valid == en[3:0], req, core_valid, en[3:0]);
    check(in_ready == en[3:0], req, in_ready, en[3:0]);
    check(core_data == in_data, "R4", core_data, in_data);
  endtask

  task automatic check_steer(input logic [7:0] en, input string req);
    dir_valid = 2'b11;
    dir_data[0] = 2'b01;
    dir_data[1] = 2'b10;
    for (int r = 0; r < 16; r++) begin
      out_ready = r[3:0];
      #1;
      for (int d = 0; d < 2; d++) begin
        int ch;
        logic [1:0] ev;
        logic er;
        ch = en[4+2*d] ? 0 : (en[5+2*d] ? 1 : -1);
        ev = (ch == 0) ? 2'b01 : (ch == 1) ? 2'b10 : 2'b00;
        er = (ch < 0) ? 1'b0 : out_ready[2*d+ch];
        check(out_valid[2*d +: 2] == ev, req, out_valid[2*d +: 2], ev);
        check(dir_ready[d] == er, "R6", dir_ready[d], er);
        if (ch >= 0)
          check(out_data[2*d+ch] == dir_data[d], req, out_data[2*d+ch], dir_data[d]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    int k;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset contents
    read_reg(2'd1, v);
    check(v == 8'hFF, "R1", v, 8'hFF);
    read_reg(2'd2, v);
    check(v == 8'h00, "R1", v, 8'h00);
    #1;
    check(out_valid == 4'h0, "R1", out_valid, 0);

    // Mask all segments, then sweep every enable pattern.
    write_reg(2'd2, 8'hFF);
    read_reg(2'd2, v);
    check(v == 8'hFF, "R2", v, 8'hFF);

    for (int e = 0; e < 256; e++) begin
      logic [7:0] en;
      en = e[7:0];
      write_reg(2'd1, en);
      read_reg(2'd1, v);
      check(v == en, "R2", v, en);
      scan_sel = 2'd1;
      check_inputs(en, "R3");
      check_steer(en, "R5");
      chain_len(n);
      k = $countones(~en);
      check(n == ((k == 0) ? 1 : 3 * k), "R7", n, (k == 0) ? 1 : 3 * k);
      // R11: partial scan selected, enabled channels still pass through
      check_inputs(en, "R11");
      out_ready = 4'hF;
      #1;
      if (en[4]) check(out_valid[0] && dir_ready[0], "R11", out_valid[0], 1);
    end

    // Directed: channels 0 and 5 in test, channel 2 masked but enabled.
    write_reg(2'd1, 8'hDE);
    write_reg(2'd2, 8'h25);
    scan_sel = 2'd3;
    chain_len(n);
    check(n == 6, "R8", n, 6);
    in_valid = 4'b0101;
    in_data = {2'd0, 2'd3, 2'd0, 2'b10};
    core_ready = 4'hF;
    dir_valid = 2'b01;
    dir_data[0] = 2'b01;
    out_ready = 4'b0011;
    #1;
    check(in_ready[2] && core_valid[2], "R8", {in_ready[2], core_valid[2]}, 3);
    check(out_valid[0] && dir_ready[0], "R11", {out_valid[0], dir_ready[0]}, 3);
    scan_capture = 1'b1;
    tick();
    scan_capture = 1'b0;
    scan_shift = 1'b1;
    begin
      logic [5:0] got, want, put;
      want = 6'b010_010; // bits: seg0 v=0? see below
      // seg0: valid=1,d0=0,d1=1 ; seg5: valid=0(not chosen), d0=1, d1=0
      want = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      put = 6'b111_000;
      for (int i = 0; i < 6; i++) begin
        got[i] = scan_tdo;
        scan_tdi = put[i];
        tick();
      end
      check(got == want, "R9", got, want);
    end
    scan_shift = 1'b0;
    scan_update = 1'b1;
    tick();
    scan_update = 1'b0;
    #1;
    check(out_valid[1] == 1'b1, "R10", out_valid[1], 1);
    check(out_data[1] == 2'b11, "R10", out_data[1], 2'b11);
    check(out_valid[0] && dir_ready[0], "R11", {out_valid[0], dir_ready[0]}, 3);
    scan_sel = 2'd1;
    #1;
    check(out_valid[1] == 1'b0, "R10", out_valid[1], 0);

    // R12: bypass delay
    scan_sel = 2'd0;
    scan_shift = 1'b1;
    scan_tdi = 1'b1;
    tick();
    check(scan_tdo == 1'b1, "R12", scan_tdo, 1);
    scan_tdi = 1'b0;
    tick();
    check(scan_tdo == 1'b0, "R12", scan_tdo, 0);
    scan_shift = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule